// File: doc/BRIEF.md
# Physical Register Reference Counter

This block tracks how many users each physical register has in a renaming core that removes register-to-register moves. When a move is eliminated, its destination is mapped onto the physical register its source already uses. One physical register can then stand behind several architectural names. A register may go back to the freelist only when the last of those names lets go of it.

Each cycle the block accepts a number of allocate requests and deallocate requests. Each request is a valid bit plus a physical register index. The block adds up the net change for every register and updates that register's counter. It flags every register whose count has just dropped to zero. These flags pass through one more register stage before they appear as a one-hot-per-register free vector for the freelist. The extra stage keeps the path from the deallocate ports to the freelist storage short.

Physical register 0 takes no part in counting. Registers below the architectural register count start out live with one user each.

Top module: `prc_top`

## Requirements
- R1: After reset, registers 1 to ARCH_REGS-1 hold a count of one and all other registers hold zero. The free vector reads all zeros.
- R2: Each valid allocate naming register r adds one to r's count. Each valid deallocate naming r subtracts one.
- R3: A register is reported free only in response to a cycle in which its count went from nonzero to zero. The report is a single-cycle pulse.
- R4: When several ports name the same register in one cycle, the count changes by the net sum of all of them.
- R5: An allocate and a deallocate of the same register in the same cycle cancel out. The register is not reported free.
- R6: Requests naming register 0 change no counter. Bit 0 of the free vector never rises.
- R7: Requests are sampled at rising edge E1, which also updates the counters. The free bit is high only in the cycle between edge E1+1 and edge E1+2.
- R8: A counter holds at least ARCH_REGS concurrent users without wrapping. The register is freed only after the last one of them is deallocated.
- R9: Several registers reaching zero in the same cycle are all reported in the same cycle of the free vector.
- R10: A counter never goes below zero. Deallocating a register whose count is zero, with no matching allocate in that cycle, is a protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| alloc_vld | input | NPORT | Valid bit per allocate port |
| alloc_idx | input | NPORT*IDX_W | Register index per allocate port; port p uses bits [p*IDX_W +: IDX_W] |
| dealloc_vld | input | NPORT | Valid bit per deallocate port |
| dealloc_idx | input | NPORT*IDX_W | Register index per deallocate port; same packing as alloc_idx |
| free_vec | output | NUM_PREGS | One bit per register, high for one cycle when that register is freed |

## Verification
Counters change at the edge that samples a request. The resulting free bit is due after the second rising edge from that request and must be gone after the third. Each directed scenario drives its request just after a falling edge and releases it after one clock. It then samples the free vector at three falling edges: the first must read zero, the second must show the expected bits, and the third must read zero again. This separates a wrong latency from a wrong value and from a pulse that lasts too long. Counts are never read directly. Instead, the number of deallocates needed before a free appears shows the count at the ports.

// File: rtl/prc_pkg.sv
package prc_pkg;
  // True when a register holds initial architectural state at reset.
  function automatic logic starts_live(input int unsigned idx, input int unsigned arch_regs);
    return (idx != 0) && (idx < arch_regs);
  endfunction
endpackage

// File: rtl/prc_match.sv
module prc_match #(
  parameter int NPORT  = 2,
  parameter int IDX_W  = 6,
  parameter int TARGET = 1,
  parameter int HW     = $clog2(NPORT + 1)
) (
  input  logic [NPORT-1:0]       vld,
  input  logic [NPORT*IDX_W-1:0] idx,
  output logic [HW-1:0]          hits
);
  always_comb begin
    hits = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (vld[p] && (idx[p*IDX_W +: IDX_W] == IDX_W'(TARGET)))
        hits = hits + HW'(1);
    end
  end
endmodule

// File: rtl/prc_cell.sv
module prc_cell #(
  parameter int   CNT_W = 7,
  parameter int   HW    = 2,
  parameter logic INIT  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [HW-1:0]    up,
  input  logic [HW-1:0]    dn,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero_hit_q
);
  localparam int EW = CNT_W + 1;
  localparam logic [EW-1:0] CMAX = EW'({CNT_W{1'b1}});

  logic [EW-1:0]    raised;
  logic [EW-1:0]    lowered;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    raised  = {1'b0, cnt_q} + EW'(up);
    lowered = '0;
    if (raised > EW'(dn))
      lowered = raised - EW'(dn);
    if (lowered > CMAX)
      cnt_nxt = CMAX[CNT_W-1:0];
    else
      cnt_nxt = lowered[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= CNT_W'(INIT);
      zero_hit_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_nxt;
      zero_hit_q <= (cnt_q != '0) && (cnt_nxt == '0);
    end
  end
endmodule

// File: rtl/prc_top.sv
module prc_top #(
  parameter int NUM_PREGS   = 64,
  parameter int ARCH_REGS   = 32,
  parameter int NPORT       = 2,
  parameter int MAX_SHARERS = 64,
  parameter int IDX_W       = $clog2(NUM_PREGS),
  parameter int CNT_W       = $clog2(MAX_SHARERS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPORT-1:0]       alloc_vld,
  input  logic [NPORT*IDX_W-1:0] alloc_idx,
  input  logic [NPORT-1:0]       dealloc_vld,
  input  logic [NPORT*IDX_W-1:0] dealloc_idx,
  output logic [NUM_PREGS-1:0]   free_vec
);
  localparam int HW = $clog2(NPORT + 1);

  logic [NUM_PREGS*CNT_W-1:0] cnt_flat;
  logic [NUM_PREGS-1:0]       zero_hit;
  logic [NUM_PREGS-1:0]       free_q;

  for (genvar r = 0; r < NUM_PREGS; r++) begin : g_reg
    if (r == 0) begin : g_hardwired
      assign cnt_flat[r*CNT_W +: CNT_W] = '0;
      assign zero_hit[r] = 1'b0;
    end else begin : g_counted
      logic [HW-1:0] up_hits;
      logic [HW-1:0] dn_hits;

      prc_match #(.NPORT(NPORT), .IDX_W(IDX_W), .TARGET(r), .HW(HW)) up_i (
        .vld(alloc_vld), .idx(alloc_idx), .hits(up_hits));

      prc_match #(.NPORT(NPORT), .IDX_W(IDX_W), .TARGET(r), .HW(HW)) dn_i (
        .vld(dealloc_vld), .idx(dealloc_idx), .hits(dn_hits));

      prc_cell #(
        .CNT_W(CNT_W), .HW(HW),
        .INIT(prc_pkg::starts_live(r, ARCH_REGS))
      ) cell_i (
        .clk(clk), .rst(rst), .up(up_hits), .dn(dn_hits),
        .cnt_q(cnt_flat[r*CNT_W +: CNT_W]), .zero_hit_q(zero_hit[r]));
    end
  end

  // Second stage: release to the freelist one cycle after the count update.
  always_ff @(posedge clk) begin
    if (rst) free_q <= '0;
    else     free_q <= zero_hit;
  end

  assign free_vec = free_q;
endmodule

// File: rtl/prc_chk.sv
module prc_chk #(
  parameter int NUM_PREGS = 64,
  parameter int ARCH_REGS = 32,
  parameter int NPORT     = 2,
  parameter int IDX_W     = 6,
  parameter int CNT_W     = 7
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NPORT-1:0]           alloc_vld,
  input logic [NPORT*IDX_W-1:0]     alloc_idx,
  input logic [NPORT-1:0]           dealloc_vld,
  input logic [NPORT*IDX_W-1:0]     dealloc_idx,
  input logic [NUM_PREGS-1:0]       free_vec,
  input logic [NUM_PREGS*CNT_W-1:0] cnt_flat
);
  logic [NPORT-1:0] underflow;

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      logic [IDX_W-1:0] t;
      logic             rescued;
      t = dealloc_idx[p*IDX_W +: IDX_W];
      rescued = 1'b0;
      for (int q = 0; q < NPORT; q++)
        if (alloc_vld[q] && alloc_idx[q*IDX_W +: IDX_W] == t) rescued = 1'b1;
      underflow[p] = dealloc_vld[p] && (t != '0) && !rescued &&
                     (cnt_flat[32'(t)*CNT_W +: CNT_W] == '0);
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      !underflow[p]); // R10
  end

  for (genvar r = 0; r < NUM_PREGS; r++) begin : g_reg
    AST_INIT_COUNTS: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> cnt_flat[r*CNT_W +: CNT_W] ==
        CNT_W'(prc_pkg::starts_live(r, ARCH_REGS))); // R1
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      free_vec[r] |=> !free_vec[r]); // R3
    AST_FREE_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
      free_vec[r] |-> ($past(cnt_flat[r*CNT_W +: CNT_W], 1) == '0) &&
                      ($past(cnt_flat[r*CNT_W +: CNT_W], 2) != '0)); // R7
  end
endmodule

bind prc_top prc_chk #(
  .NUM_PREGS(NUM_PREGS), .ARCH_REGS(ARCH_REGS), .NPORT(NPORT),
  .IDX_W(IDX_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst),
  .alloc_vld(alloc_vld), .alloc_idx(alloc_idx),
  .dealloc_vld(dealloc_vld), .dealloc_idx(dealloc_idx),
  .free_vec(free_vec), .cnt_flat(cnt_flat)
);

// File: tb/prc_top_tb.sv
module prc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP    = 64;
  localparam int NPORT = 2;
  localparam int IDX_W = 6;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [NPORT-1:0]       alloc_vld = '0;
  logic [NPORT*IDX_W-1:0] alloc_idx = '0;
  logic [NPORT-1:0]       dealloc_vld = '0;
  logic [NPORT*IDX_W-1:0] dealloc_idx = '0;
  logic [NP-1:0]          free_vec;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  prc_top dut_i (
    .clk(clk), .rst(rst),
    .alloc_vld(alloc_vld), .alloc_idx(alloc_idx),
    .dealloc_vld(dealloc_vld), .dealloc_idx(dealloc_idx),
    .free_vec(free_vec));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <=20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [NP-1:0] bit_of(input int r);
    return NP'(1) << r;
  endfunction

  task automatic check(input string tag, input logic [NP-1:0] exp);
    checks++;
    if (free_vec !== exp) begin
      fails++;
      $display("FAIL %s: free_vec actual=%h expected=%h", tag, free_vec, exp);
    end
  endtask

  // Drive one request cycle; returns just after the following falling edge.
  task automatic apply(input logic [1:0] av, input int a0, input int a1,
                       input logic [1:0] dv, input int d0, input int d1);
    @(negedge clk);
    alloc_vld   = av;
    alloc_idx   = {IDX_W'(a1), IDX_W'(a0)};
    dealloc_vld = dv;
    dealloc_idx = {IDX_W'(d1), IDX_W'(d0)};
    @(posedge clk);
    @(negedge clk);
    alloc_vld   = '0;
    dealloc_vld = '0;
  endtask

  // Request, then look at the free vector after edges E1, E1+1, E1+2.
  task automatic watch(input string tag, input logic [1:0] av, input int a0, input int a1,
                       input logic [1:0] dv, input int d0, input int d1,
                       input logic [NP-1:0] exp);
    apply(av, a0, a1, dv, d0, d1);
    check({tag, " R7 early"}, '0);
    @(posedge clk); @(negedge clk);
    check(tag, exp);
    @(posedge clk); @(negedge clk);
    check({tag, " R3 pulse end"}, '0);
  endtask

  task automatic t_reset;
    check("R1 reset free_vec", '0);
    watch("R1 reg7 starts at one", 2'b00, 0, 0, 2'b01, 7, 0, bit_of(7));
  endtask

  task automatic t_inc_dec;
    apply(2'b01, 40, 0, 2'b00, 0, 0);
    apply(2'b10, 0, 40, 2'b00, 0, 0);
    watch("R2 reg40 still shared", 2'b00, 0, 0, 2'b01, 40, 0, '0);
    watch("R2 reg40 last user", 2'b00, 0, 0, 2'b10, 0, 40, bit_of(40));
  endtask

  task automatic t_multi_port;
    apply(2'b11, 41, 41, 2'b00, 0, 0);
    watch("R4 reg41 net of two", 2'b00, 0, 0, 2'b11, 41, 41, bit_of(41));
  endtask

  task automatic t_cancel;
    watch("R5 reg8 alloc+dealloc", 2'b01, 8, 0, 2'b01, 8, 0, '0);
    watch("R5 reg8 after cancel", 2'b00, 0, 0, 2'b10, 0, 8, bit_of(8));
  endtask

  task automatic t_reg_zero;
    apply(2'b11, 0, 0, 2'b00, 0, 0);
    watch("R6 reg0 dealloc", 2'b00, 0, 0, 2'b11, 0, 0, '0);
    watch("R6 reg0 beside reg11", 2'b00, 0, 0, 2'b11, 0, 11, bit_of(11));
  endtask

  task automatic t_two_free;
    watch("R9 regs 9 and 10", 2'b00, 0, 0, 2'b11, 9, 10, bit_of(9) | bit_of(10));
  endtask

  task automatic t_deep;
    for (int i = 0; i < 16; i++) apply(2'b11, 50, 50, 2'b00, 0, 0);
    for (int i = 0; i < 15; i++) apply(2'b00, 0, 0, 2'b11, 50, 50);
    watch("R8 reg50 one user left", 2'b00, 0, 0, 2'b01, 50, 0, '0);
    watch("R8 reg50 after 32 users", 2'b00, 0, 0, 2'b01, 50, 0, bit_of(50));
  endtask

  task automatic t_no_decrement_zero;
    // R10: reg 12 freed once; a re-allocate brings it back to one user
    watch("R10 reg12 first free", 2'b00, 0, 0, 2'b01, 12, 0, bit_of(12));
    apply(2'b01, 12, 0, 2'b00, 0, 0);
    watch("R10 reg12 reused", 2'b00, 0, 0, 2'b01, 12, 0, bit_of(12));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_inc_dec();
    t_multi_port();
    t_cancel();
    t_reg_zero();
    t_two_free();
    t_deep();
    t_no_decrement_zero();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule